// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between an internal request port and an external 256K x 8 asynchronous static RAM. A client offers one word at a time on a valid/ready handshake, either a write (address plus byte) or a read (address only). The controller then produces the memory's control waveforms from its own flops: two chip selects of opposite polarity, a write strobe, an output enable, an 18-bit address and a byte-wide data path. The data path is split into an output byte, an output-enable for the pad tristate and an input byte. Every analogue timing limit is met by holding each phase for a whole number of system clocks. Each count is the nanosecond limit divided by the clock period and rounded up. The nanosecond limits come from a speed-grade parameter (70, 85 or 100).

Reads hold the chip selected with output enable asserted for the full access time. The returned byte is latched on the last cycle of that window and presented with a single-cycle valid strobe. After a read, the chip is deselected for the output turn-off time before anything else happens, so the controller never drives the bus while the memory may still be driving it. Writes hold address and data steady across the whole strobe and keep data driven one cycle past the strobe's rising edge. A standby request parks the memory deselected. On release, the controller waits out a long recovery period before it accepts new work.

Top module: `sram_async_ctl`

## Requirements
- R1: While reset is asserted and right after it, the memory is deselected (sram_cs1_n=1, sram_cs2=0), sram_we_n=1, sram_oe_n=1, sram_dq_oe=0 and rsp_valid=0.
- R2: A read holds sram_cs1_n=0, sram_cs2=1, sram_we_n=1, sram_oe_n=0 and a constant address for exactly N_RD cycles, where N_RD is the larger of the read-cycle and address-access times divided by the clock period, rounded up. The byte present on sram_dq_i in the last of those cycles appears on rsp_rdata with rsp_valid high for exactly one cycle, starting the cycle after.
- R3: A write holds sram_we_n=0 for exactly N_WP cycles, where N_WP is the largest of the write-pulse, address-to-end, select-to-end and data-setup times divided by the clock period, rounded up. The chip stays selected, and address, sram_dq_o and sram_dq_oe=1 stay constant throughout.
- R4: sram_dq_oe stays 1 for exactly one cycle after sram_we_n returns high, then drops to 0 before the write occupancy of N_WC cycles ends. N_WC is the larger of the write-cycle time in cycles and N_WP+2.
- R5: sram_dq_oe is never 1 while sram_oe_n=0, nor within the output turn-off time after a read. A read is always followed by N_HZ deselected cycles before the next access.
- R6: req_ready is 1 only when the controller is idle and stby_req=0. After acceptance it stays low for N_RD+N_HZ cycles for a read and N_WC cycles for a write.
- R7: With stby_req=1 while idle, the controller enters standby on the next edge. In standby, stby_ack=1, the memory is deselected and req_ready=0, so requests have no effect on pins or memory contents.
- R8: When stby_req drops in standby, req_ready stays 0 for N_REC cycles, where N_REC is RECOVERY_NS divided by the clock period, rounded up. Then the controller returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write byte |
| rsp_valid | output | 1 | One-cycle strobe for read data |
| rsp_rdata | output | DATA_W | Captured read byte |
| stby_req | input | 1 | Level request for standby |
| stby_ack | output | 1 | High while in standby |
| sram_addr | output | ADDR_W | Memory address |
| sram_cs1_n | output | 1 | Active-low chip select |
| sram_cs2 | output | 1 | Active-high chip select |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_dq_o | output | DATA_W | Byte to drive on the data pins |
| sram_dq_oe | output | 1 | Tristate enable for sram_dq_o |
| sram_dq_i | input | DATA_W | Byte sampled from the data pins |

## Verification
The bench's memory model returns an inverted byte until the access count is reached. A controller that samples early therefore hands back corrupted data. The model also keeps the bus busy for the turn-off time after every read, so a write issued straight after a read exposes a missing or short turnaround as contention. Write strobes are measured in cycles, and the byte is only committed if address and data stayed put. A short pulse or an early bus release therefore shows up either as a pulse-width failure or as a wrong byte on the later read. Requests held during standby must leave the pins and the stored data alone, and the recovery wait is timed to the cycle against the ready line.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_TURN,
    ST_STBY,
    ST_RECOV
  } ctl_state_e;

  typedef enum logic [3:0] {
    TS_RDCYC,
    TS_ACCESS,
    TS_OEVAL,
    TS_HIZ,
    TS_WRCYC,
    TS_STROBE,
    TS_ADDR_END,
    TS_SEL_END,
    TS_DSETUP
  } tsel_e;

  // nanosecond limit for one timing parameter of a speed grade;
  // unknown grades fall back to the slowest column
  function automatic int grade_ns(input int grade, input tsel_e sel);
    int col;
    int v;
    col = (grade == 70) ? 0 : (grade == 85) ? 1 : 2;
    case (sel)
      TS_RDCYC, TS_ACCESS, TS_WRCYC: v = (col == 0) ? 70 : (col == 1) ? 85 : 100;
      TS_OEVAL:                      v = (col == 0) ? 40 : (col == 1) ? 45 : 50;
      TS_HIZ:                        v = (col == 0) ? 20 : (col == 1) ? 25 : 30;
      TS_STROBE:                     v = (col == 0) ? 50 : (col == 1) ? 60 : 70;
      TS_ADDR_END, TS_SEL_END:       v = (col == 0) ? 60 : (col == 1) ? 70 : 80;
      TS_DSETUP:                     v = (col == 2) ? 40 : 35;
      default:                       v = 100;
    endcase
    return v;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // cycles covering ns, never fewer than one
  function automatic int ns_to_cyc(input int ns, input int period);
    return max2(1, (ns + period - 1) / period);
  endfunction

endpackage

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int N_RD  = 18,
  parameter int N_HZ  = 5,
  parameter int N_WC  = 18,
  parameter int N_REC = 100,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             stby_req,
  output ctl_state_e       state_q,
  output ctl_state_e       state_d,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d,
  output logic             req_ready,
  output logic             accept
);

  logic [CNT_W-1:0] last_cnt;
  logic             phase_done;

  always_comb begin
    case (state_q)
      ST_READ:  last_cnt = CNT_W'(N_RD - 1);
      ST_WRITE: last_cnt = CNT_W'(N_WC - 1);
      ST_TURN:  last_cnt = CNT_W'(N_HZ - 1);
      ST_RECOV: last_cnt = CNT_W'(N_REC - 1);
      default:  last_cnt = '0;
    endcase
  end

  assign phase_done = (cnt_q == last_cnt);
  assign req_ready  = (state_q == ST_IDLE) && !stby_req;
  assign accept     = req_ready && req_valid;

  // next-state process
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (stby_req)       state_d = ST_STBY;
        else if (req_valid) state_d = req_write ? ST_WRITE : ST_READ;
      end
      ST_READ, ST_WRITE, ST_TURN, ST_RECOV: begin
        if (phase_done) begin
          cnt_d   = '0;
          state_d = (state_q == ST_READ) ? ST_TURN : ST_IDLE;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_STBY: begin
        cnt_d = '0;
        if (!stby_req) state_d = ST_RECOV;
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/sram_ctl_pins.sv
module sram_ctl_pins
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8,
  parameter int N_WP   = 15,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_state_e        state_d,
  input  logic [CNT_W-1:0]  cnt_d,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_cs1_n,
  output logic              sram_cs2,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic              sram_dq_oe
);

  logic sel_d;
  logic strobe_d;
  logic drive_d;
  logic rden_d;

  // pin levels for the cycle that follows, decoded from the next state
  always_comb begin
    sel_d    = (state_d == ST_READ) || (state_d == ST_WRITE);
    rden_d   = (state_d == ST_READ);
    strobe_d = (state_d == ST_WRITE) && (cnt_d < CNT_W'(N_WP));
    drive_d  = (state_d == ST_WRITE) && (cnt_d <= CNT_W'(N_WP));
  end

  // control lines come straight from flops so the memory sees no decode glitches
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sram_cs1_n <= 1'b1;
      sram_cs2   <= 1'b0;
      sram_we_n  <= 1'b1;
      sram_oe_n  <= 1'b1;
      sram_dq_oe <= 1'b0;
    end else begin
      sram_cs1_n <= !sel_d;
      sram_cs2   <= sel_d;
      sram_we_n  <= !strobe_d;
      sram_oe_n  <= !rden_d;
      sram_dq_oe <= drive_d;
    end
  end

  // address and write byte are captured once per accepted request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sram_addr <= '0;
      sram_dq_o <= '0;
    end else if (accept) begin
      sram_addr <= req_addr;
      sram_dq_o <= req_wdata;
    end
  end

endmodule

// File: rtl/sram_ctl_rdcap.sv
module sram_ctl_rdcap
  import sram_ctl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int N_RD   = 18,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_state_e        state_q,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic [DATA_W-1:0] sram_dq_i,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic take;

  assign take = (state_q == ST_READ) && (cnt_q == CNT_W'(N_RD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= take;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata <= '0;
    end else if (take) begin
      rsp_rdata <= sram_dq_i;
    end
  end

endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W        = 18,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 4,
  parameter int SPEED_GRADE   = 70,
  parameter int RECOVERY_NS   = 5000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              stby_req,
  output logic              stby_ack,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_cs1_n,
  output logic              sram_cs2,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_i
);

  localparam int T_ACC = max2(max2(grade_ns(SPEED_GRADE, TS_RDCYC),
                                   grade_ns(SPEED_GRADE, TS_ACCESS)),
                              grade_ns(SPEED_GRADE, TS_OEVAL));
  localparam int T_STR = max2(max2(grade_ns(SPEED_GRADE, TS_STROBE),
                                   grade_ns(SPEED_GRADE, TS_DSETUP)),
                              max2(grade_ns(SPEED_GRADE, TS_ADDR_END),
                                   grade_ns(SPEED_GRADE, TS_SEL_END)));
  localparam int N_RD    = ns_to_cyc(T_ACC, CLK_PERIOD_NS);
  localparam int N_HZ    = ns_to_cyc(grade_ns(SPEED_GRADE, TS_HIZ), CLK_PERIOD_NS);
  localparam int N_WP    = ns_to_cyc(T_STR, CLK_PERIOD_NS);
  localparam int N_WC    = max2(ns_to_cyc(grade_ns(SPEED_GRADE, TS_WRCYC), CLK_PERIOD_NS), N_WP + 2);
  localparam int N_REC   = ns_to_cyc(RECOVERY_NS, CLK_PERIOD_NS);
  localparam int CNT_MAX = max2(max2(N_RD, N_HZ), max2(N_WC, N_REC));
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q;
  logic rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  ctl_state_e       state_q;
  ctl_state_e       state_d;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             accept;

  sram_ctl_fsm #(
    .N_RD (N_RD),
    .N_HZ (N_HZ),
    .N_WC (N_WC),
    .N_REC(N_REC),
    .CNT_W(CNT_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .req_valid(req_valid),
    .req_write(req_write),
    .stby_req (stby_req),
    .state_q  (state_q),
    .state_d  (state_d),
    .cnt_q    (cnt_q),
    .cnt_d    (cnt_d),
    .req_ready(req_ready),
    .accept   (accept)
  );

  sram_ctl_pins #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .N_WP  (N_WP),
    .CNT_W (CNT_W)
  ) u_pins (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .state_d   (state_d),
    .cnt_d     (cnt_d),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .sram_addr (sram_addr),
    .sram_dq_o (sram_dq_o),
    .sram_cs1_n(sram_cs1_n),
    .sram_cs2  (sram_cs2),
    .sram_we_n (sram_we_n),
    .sram_oe_n (sram_oe_n),
    .sram_dq_oe(sram_dq_oe)
  );

  sram_ctl_rdcap #(
    .DATA_W(DATA_W),
    .N_RD  (N_RD),
    .CNT_W (CNT_W)
  ) u_rdcap (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .state_q  (state_q),
    .cnt_q    (cnt_q),
    .sram_dq_i(sram_dq_i),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );

  assign stby_ack = (state_q == ST_STBY);

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stby_req,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              stby_ack,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_cs1_n,
  input logic              sram_cs2,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic              sram_dq_oe
);

  // R2
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R3
  strobe_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (!sram_cs1_n && sram_cs2));

  // R3
  strobe_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_we_n && $past(!sram_we_n)) |-> $stable(sram_addr));

  // R4
  release_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_dq_oe) |-> (sram_we_n && $past(sram_we_n)));

  // R5
  no_drive_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> !sram_dq_oe);

  // R6
  ready_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !stby_req);

  // R7
  standby_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stby_ack |-> (sram_cs1_n && !sram_cs2 && !req_ready && !sram_dq_oe));

endmodule

bind sram_async_ctl sram_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .stby_req  (stby_req),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .stby_ack  (stby_ack),
  .sram_addr (sram_addr),
  .sram_cs1_n(sram_cs1_n),
  .sram_cs2  (sram_cs2),
  .sram_we_n (sram_we_n),
  .sram_oe_n (sram_oe_n),
  .sram_dq_oe(sram_dq_oe)
);

// File: tb/sim_sram_async_ctl.sv
module sim_sram_async_ctl;

  localparam int PER    = 4;
  localparam int REC_NS = 400;
  // expected counts derived from the 70 ns column at 4 ns
  localparam int E_RD  = (70 + PER - 1) / PER;
  localparam int E_HZ  = (20 + PER - 1) / PER;
  localparam int E_WP  = (60 + PER - 1) / PER;
  localparam int E_WC  = ((70 + PER - 1) / PER > E_WP + 2) ? (70 + PER - 1) / PER : E_WP + 2;
  localparam int E_REC = (REC_NS + PER - 1) / PER;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [17:0] req_addr;
  logic [7:0]  req_wdata;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic        stby_req;
  logic        stby_ack;
  logic [17:0] sram_addr;
  logic        sram_cs1_n;
  logic        sram_cs2;
  logic        sram_we_n;
  logic        sram_oe_n;
  logic [7:0]  sram_dq_o;
  logic        sram_dq_oe;
  logic [7:0]  mem_dq;

  int n_chk;
  int n_fail;
  bit done;

  sram_async_ctl #(
    .CLK_PERIOD_NS(PER),
    .SPEED_GRADE  (70),
    .RECOVERY_NS  (REC_NS)
  ) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .stby_req  (stby_req),
    .stby_ack  (stby_ack),
    .sram_addr (sram_addr),
    .sram_cs1_n(sram_cs1_n),
    .sram_cs2  (sram_cs2),
    .sram_we_n (sram_we_n),
    .sram_oe_n (sram_oe_n),
    .sram_dq_o (sram_dq_o),
    .sram_dq_oe(sram_dq_oe),
    .sram_dq_i (mem_dq)
  );

  initial clk = 1'b0;
  always #(PER / 2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // ---------------- reference model, advanced on every rising edge
  logic [7:0] ref_mem [int];
  int         ref_left;
  bit         ref_stby;
  bit         ref_rec;
  int         rsp_cnt;
  bit         rsp_exp;
  logic [7:0] exp_byte;

  always @(posedge clk) begin
    if (!rst_n) begin
      ref_left = 0; ref_stby = 0; ref_rec = 0; rsp_cnt = 0; rsp_exp = 0;
    end else begin
      rsp_exp = 0;
      if (rsp_cnt > 0) begin
        rsp_cnt--;
        if (rsp_cnt == 0) rsp_exp = 1;
      end
      if (ref_left > 0) begin
        ref_left--;
      end else if (ref_stby) begin
        if (!stby_req) begin
          ref_stby = 0;
          ref_rec  = 1;
          ref_left = E_REC;
        end
      end else begin
        ref_rec = 0;
        if (stby_req) begin
          ref_stby = 1;
        end else if (req_valid) begin
          if (req_write) begin
            ref_mem[int'(req_addr)] = req_wdata;
            ref_left = E_WC;
          end else begin
            exp_byte = ref_mem.exists(int'(req_addr)) ? ref_mem[int'(req_addr)] : 8'h00;
            ref_left = E_RD + E_HZ;
            rsp_cnt  = E_RD;
          end
        end
      end
    end
  end

  // ---------------- per-cycle comparison of the request side
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(req_ready == (ref_left == 0 && !ref_stby && !stby_req),
          ref_rec ? "R8 ready" : "R6 ready", req_ready,
          (ref_left == 0 && !ref_stby && !stby_req));
      chk(stby_ack == ref_stby, "R7 ack", stby_ack, ref_stby);
      chk(rsp_valid == rsp_exp, "R2 rsp_valid", rsp_valid, rsp_exp);
      if (rsp_exp) chk(rsp_rdata == exp_byte, "R2 rdata", rsp_rdata, exp_byte);
    end
  end

  // ---------------- behavioural memory with pulse and contention checks
  logic [7:0]  mdl_mem [int];
  int          wcnt;
  int          acc;
  int          hz;
  bit          rd_prev;
  bit          rel_chk;
  logic [17:0] waddr;
  logic [17:0] raddr;
  logic [7:0]  wbyte;

  always @(negedge clk) begin
    bit sel;
    bit wr;
    bit rd;
    bit busy;
    if (!rst_n) begin
      wcnt = 0; acc = 0; hz = 0; rd_prev = 0; rel_chk = 0; mem_dq = 8'h00;
    end else begin
      sel  = !sram_cs1_n && sram_cs2;
      wr   = sel && !sram_we_n;
      rd   = sel && sram_we_n && !sram_oe_n;
      busy = rd || (hz > 0);
      if (sram_dq_oe && busy) chk(1'b0, "R5 bus contention", 1, 0);
      if (stby_ack && sel) chk(1'b0, "R7 selected in standby", 1, 0);
      if (wr) begin
        if (wcnt > 0)
          chk(sram_addr == waddr && sram_dq_o == wbyte && sram_dq_oe,
              "R3 write hold", sram_addr, waddr);
        else
          chk(sram_dq_oe == 1'b1, "R3 data driven", sram_dq_oe, 1);
        waddr = sram_addr;
        wbyte = sram_dq_o;
        wcnt++;
      end else if (wcnt > 0) begin
        chk(wcnt == E_WP, "R3 strobe width", wcnt, E_WP);
        chk(sram_dq_oe == 1'b1 && sram_dq_o == wbyte, "R4 data hold", sram_dq_oe, 1);
        if (wcnt >= E_WP) mdl_mem[int'(waddr)] = wbyte;
        wcnt    = 0;
        rel_chk = 1;
      end else if (rel_chk) begin
        chk(sram_dq_oe == 1'b0, "R4 release", sram_dq_oe, 0);
        rel_chk = 0;
      end
      if (rd) begin
        if (rd_prev && sram_addr == raddr) acc++;
        else acc = 1;
        raddr = sram_addr;
        if (mdl_mem.exists(int'(sram_addr)))
          mem_dq = (acc >= E_RD) ? mdl_mem[int'(sram_addr)] : ~mdl_mem[int'(sram_addr)];
        else
          mem_dq = 8'h00;
      end else begin
        if (rd_prev) chk(acc == E_RD, "R2 read window", acc, E_RD);
        mem_dq = 8'h00;
      end
      rd_prev = rd;
      if (rd) hz = E_HZ;
      else if (hz > 0) hz--;
    end
  end

  // ---------------- stimulus
  task automatic issue(input bit wr, input logic [17:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) begin
      @(negedge clk); #1;
    end
    @(negedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic idle_for(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; stby_req = 1'b0; mem_dq = 8'h00;
    repeat (3) @(negedge clk);
    // R1: parked pins in reset
    chk(sram_cs1_n == 1'b1, "R1 cs1_n", sram_cs1_n, 1);
    chk(sram_cs2 == 1'b0, "R1 cs2", sram_cs2, 0);
    chk(sram_we_n == 1'b1, "R1 we_n", sram_we_n, 1);
    chk(sram_oe_n == 1'b1, "R1 oe_n", sram_oe_n, 1);
    chk(sram_dq_oe == 1'b0, "R1 dq_oe", sram_dq_oe, 0);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
    #1 rst_n = 1'b1;
    idle_for(4);
    chk(sram_cs1_n == 1'b1 && sram_cs2 == 1'b0, "R1 after release", sram_cs1_n, 1);

    // R3 R4: writes at both address ends and in between
    issue(1'b1, 18'h00000, 8'hA5);
    issue(1'b1, 18'h3FFFF, 8'h3C);
    issue(1'b1, 18'h12345, 8'h81);
    issue(1'b1, 18'h00005, 8'h11);
    // R2 R5: reads, back to back
    issue(1'b0, 18'h00000, 8'h00);
    issue(1'b0, 18'h3FFFF, 8'h00);
    issue(1'b0, 18'h12345, 8'h00);
    // R5: write straight after a read, then read it back
    issue(1'b1, 18'h00007, 8'h77);
    issue(1'b0, 18'h00007, 8'h00);
    issue(1'b1, 18'h12345, 8'h00);
    issue(1'b0, 18'h12345, 8'h00);
    idle_for(30);

    // R7: requests offered during standby have no effect
    stby_req = 1'b1;
    idle_for(6);
    chk(stby_ack == 1'b1, "R7 entered", stby_ack, 1);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h00005; req_wdata = 8'hEE;
    idle_for(20);
    chk(req_ready == 1'b0, "R7 ready held low", req_ready, 0);
    req_valid = 1'b0;
    // R8: recovery wait after release
    stby_req = 1'b0;
    issue(1'b0, 18'h00005, 8'h00);
    idle_for(40);
    chk(mdl_mem.exists(5) && mdl_mem[5] == 8'h11, "R7 memory untouched",
        mdl_mem.exists(5) ? int'(mdl_mem[5]) : -1, 8'h11);
    done = 1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      chk(1'b0, "watchdog", 0, 1);
      finish_run();
    end
  end

endmodule